// File: doc/BRIEF.md
# Application Bus Register and FIFO Port Decoder

This block is an 8-bit bus slave that lets application logic reach a few control and status registers and the streaming data ports of a set of endpoint FIFOs. The application drives a direction line (high for write, low for read), an active-low strobe, an 8-bit address and an 8-bit write-data bus. Read data returns on a separate 8-bit output bus, so no tri-state bus is involved.

The strobe is brought into the system clock domain through a three-stage shift register. Each high-to-low transition of the synchronized strobe starts exactly one access, however long the strobe then stays low. A write lands in a control register, or becomes a one-cycle push request (with its data byte) toward the transmit FIFO of the addressed endpoint. A read captures a register value, or the head byte of the addressed receive FIFO together with a one-cycle pop request, into the read-data register. Addresses that map to nothing read back as zero and swallow writes.

Top module: `appbus_regif`

## Requirements
- R1: After reset, `ctrl0`, `ctrl1`, `dout`, `tx_data`, `tx_push` and `rx_pop` are all zero.
- R2: A write cycle (`wr_rd`=1) to address 0x00 loads `din` into `ctrl0`, and one to 0x01 loads `ctrl1`; the new value appears on the third rising clock edge after `strb_n` falls.
- R3: A read cycle (`wr_rd`=0) at 0x00, 0x01 or 0x02 places `ctrl0`, `ctrl1` or `stat_in` respectively on `dout` on the third rising edge after `strb_n` falls.
- R4: A write at address PORT_BASE+k (default 0x10+k, k below NUM_EP) raises bit k of `tx_push` for exactly one cycle, with `tx_data` equal to `din` in that cycle, and leaves both control registers unchanged.
- R5: A read at PORT_BASE+k raises bit k of `rx_pop` for exactly one cycle and puts byte k of `rx_data` (bits 8k+7..8k) on `dout`.
- R6: Each strobe-low period yields exactly one access, whether the strobe stays low for three cycles or for many.
- R7: A read from an unmapped address (any address other than 0x00–0x02 and the data ports) returns 0x00 on `dout` and raises no pop.
- R8: A write to an unmapped address or to the read-only status address 0x02 changes neither control register and raises no push.
- R9: At most one bit of `tx_push` and `rx_pop` taken together is high in any cycle.
- R10: `dout` changes only as the result of a read cycle; it holds its value across write cycles and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_rd | input | 1 | Access direction: 1 write, 0 read |
| strb_n | input | 1 | Access strobe, active low |
| addr | input | 8 | Access address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| stat_in | input | 8 | Status byte returned at address 0x02 |
| ctrl0 | output | 8 | Control register at 0x00 |
| ctrl1 | output | 8 | Control register at 0x01 |
| tx_push | output | NUM_EP | One-hot push request per transmit FIFO |
| tx_data | output | 8 | Byte that accompanies a push |
| rx_pop | output | NUM_EP | One-hot pop request per receive FIFO |
| rx_data | input | 8*NUM_EP | Head byte of each receive FIFO, endpoint k in bits 8k+7..8k |

## Verification
Every result of an access is due on the third rising clock edge after the strobe falls: two edges to pass the strobe through the synchronizer and one to register the action. Push and pop requests last exactly one cycle, so the bench samples all outputs at falling clock edges and accumulates every push and pop seen over the whole window from strobe fall until four cycles after strobe release; it then compares the number of pulses, the bits set and the data against its model. Register contents and `dout` are compared once the window closes, when no further change is allowed.

// File: rtl/appbus_regif.sv
module appbus_regif #(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int NUM_EP    = 4,
  parameter int PORT_BASE = 16,
  parameter int A_CTRL0   = 0,
  parameter int A_CTRL1   = 1,
  parameter int A_STAT    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_rd,
  input  logic                 strb_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        din,
  output logic [DW-1:0]        dout,
  input  logic [DW-1:0]        stat_in,
  output logic [DW-1:0]        ctrl0,
  output logic [DW-1:0]        ctrl1,
  output logic [NUM_EP-1:0]    tx_push,
  output logic [DW-1:0]        tx_data,
  output logic [NUM_EP-1:0]    rx_pop,
  input  logic [NUM_EP*DW-1:0] rx_data
);
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [AW:0] PB = (AW+1)'(PORT_BASE);
  localparam logic [AW:0] PE = (AW+1)'(PORT_BASE + NUM_EP);

  logic [2:0]     sync;
  logic           fall;
  logic           hit_port;
  logic [EPW-1:0] ep;
  logic [AW-1:0]  ep_off;
  logic [DW-1:0]  rd_val;

  always_ff @(posedge clk) begin
    if (rst) sync <= 3'b111;
    else     sync <= {sync[1:0], strb_n};
  end

  assign fall     = sync[2] & ~sync[1];
  assign hit_port = ({1'b0, addr} >= PB) && ({1'b0, addr} < PE);
  assign ep_off   = addr - PB[AW-1:0];
  assign ep       = ep_off[EPW-1:0];

  always_comb begin
    rd_val = '0;
    if (hit_port)                      rd_val = rx_data[ep*DW +: DW];
    else if (addr == AW'(A_CTRL0))     rd_val = ctrl0;
    else if (addr == AW'(A_CTRL1))     rd_val = ctrl1;
    else if (addr == AW'(A_STAT))      rd_val = stat_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      ctrl0   <= '0;
      ctrl1   <= '0;
      tx_push <= '0;
      tx_data <= '0;
      rx_pop  <= '0;
    end else begin
      tx_push <= '0;
      rx_pop  <= '0;
      if (fall) begin
        if (wr_rd) begin
          if (hit_port) begin
            tx_push <= NUM_EP'(1) << ep;
            tx_data <= din;
          end else if (addr == AW'(A_CTRL0)) begin
            ctrl0 <= din;
          end else if (addr == AW'(A_CTRL1)) begin
            ctrl1 <= din;
          end
        end else begin
          dout <= rd_val;
          if (hit_port) rx_pop <= NUM_EP'(1) << ep;
        end
      end
    end
  end

  p_single_req_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_push, rx_pop}));

  p_push_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (|tx_push) |=> !(|tx_push));

  p_pop_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (|rx_pop) |=> !(|rx_pop));

  p_push_is_write_r4: assert property (@(posedge clk) disable iff (rst)
    (|tx_push) |-> $past(wr_rd));

  p_pop_is_read_r5: assert property (@(posedge clk) disable iff (rst)
    (|rx_pop) |-> !$past(wr_rd));

  p_ctrl0_by_write_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl0) |-> $past(wr_rd && addr == AW'(A_CTRL0)));

  p_dout_by_read_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> !$past(wr_rd));
endmodule

// File: tb/sim_appbus_regif.sv
module sim_appbus_regif;
  localparam int NE = 4;
  localparam int PB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_rd = 1'b0;
  logic strb_n = 1'b1;
  logic [7:0] addr = '0, din = '0, stat_in = '0;
  logic [NE*8-1:0] rx_data = '0;
  logic [7:0] dout, ctrl0, ctrl1, tx_data;
  logic [NE-1:0] tx_push, rx_pop;

  int vectors = 0, miscompares = 0;
  logic [7:0] m_c0 = '0, m_c1 = '0, m_dout = '0;

  always #2.5 clk = ~clk;

  appbus_regif #(.NUM_EP(NE), .PORT_BASE(PB)) u0 (
    .clk(clk), .rst(rst), .wr_rd(wr_rd), .strb_n(strb_n), .addr(addr),
    .din(din), .dout(dout), .stat_in(stat_in), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_port(logic [7:0] a);
    return (a >= PB) && (a < PB + NE);
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (is_port(a)) return rx_data[(a - PB)*8 +: 8];
    if (a == 8'h00) return m_c0;
    if (a == 8'h01) return m_c1;
    if (a == 8'h02) return stat_in;
    return 8'h00;
  endfunction

  task automatic access(bit wr, logic [7:0] a, logic [7:0] d, int hold);
    logic [NE-1:0] push_or = '0, pop_or = '0;
    int push_n = 0, pop_n = 0;
    logic [7:0] txd = '0;
    logic [NE-1:0] e_push, e_pop;
    @(negedge clk);
    stat_in = 8'($urandom);
    rx_data = {$urandom, $urandom};
    wr_rd = wr; addr = a; din = d; strb_n = 1'b0;
    for (int i = 0; i < 3 + hold + 4; i++) begin
      @(negedge clk);
      if (i == 3 + hold - 1) strb_n = 1'b1;
      if (|tx_push) begin push_n++; push_or |= tx_push; txd = tx_data; end
      if (|rx_pop)  begin pop_n++;  pop_or  |= rx_pop; end
    end
    e_push = (wr && is_port(a)) ? NE'(1) << (a - PB) : '0;
    e_pop  = (!wr && is_port(a)) ? NE'(1) << (a - PB) : '0;
    if (wr) begin
      if (a == 8'h00) m_c0 = d;
      else if (a == 8'h01) m_c1 = d;
    end else begin
      m_dout = exp_read(a);
    end
    check("R4 push mask", 32'(push_or), 32'(e_push));
    check("R6 push count", push_n, (e_push != 0) ? 1 : 0);
    if (e_push != 0) check("R4 tx_data", 32'(txd), 32'(d));
    check("R5 pop mask", 32'(pop_or), 32'(e_pop));
    check("R6 pop count", pop_n, (e_pop != 0) ? 1 : 0);
    check("R2/R8 ctrl0", 32'(ctrl0), 32'(m_c0));
    check("R2/R8 ctrl1", 32'(ctrl1), 32'(m_c1));
    check(wr ? "R10 dout held" : "R3/R5/R7 dout", 32'(dout), 32'(m_dout));
  endtask

  initial begin
    int n;
    #(5 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] pick [12];
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ctrl0", 32'(ctrl0), 0);
    check("R1 ctrl1", 32'(ctrl1), 0);
    check("R1 dout", 32'(dout), 0);
    check("R1 tx_data", 32'(tx_data), 0);
    check("R1 push/pop", 32'({tx_push, rx_pop}), 0);

    access(1, 8'h00, 8'hA5, 0);          // R2 ctrl0 write
    access(1, 8'h01, 8'h3C, 0);          // R2 ctrl1 write
    access(0, 8'h00, 8'h00, 0);          // R3
    access(0, 8'h01, 8'h00, 0);          // R3
    access(0, 8'h02, 8'h00, 0);          // R3 status
    access(1, 8'h02, 8'hFF, 0);          // R8 write to status ignored
    access(1, 8'hFF, 8'h11, 0);          // R8 unmapped write
    access(0, 8'hFF, 8'h00, 0);          // R7 unmapped read
    access(1, 8'(PB + NE - 1), 8'h5A, 25); // R4/R6 long strobe on last port
    access(0, 8'(PB), 8'h00, 25);        // R5/R6 long strobe on first port
    access(0, 8'(PB + NE), 8'h00, 0);    // R7 just past the ports
    access(0, 8'(PB - 1), 8'h00, 0);     // R7 just below the ports

    pick = '{8'h00, 8'h01, 8'h02, 8'(PB), 8'(PB+1), 8'(PB+2), 8'(PB+3),
             8'h05, 8'(PB+NE), 8'hFF, 8'h80, 8'h00};
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : pick[$urandom_range(0, 11)];
      access(1'($urandom), a, 8'($urandom), $urandom_range(0, 6));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule